// File: doc/BRIEF.md
# Edge-Armed Burst Pulse Generator

This block is a synchronous one-shot for a slowly moving control level. When the trigger input is seen to rise while the block is armed, the output produces a burst of `NUM_PULSES` pulses. Each pulse is one clock period long, and consecutive pulses are separated by one low cycle. With the default of 3 the burst takes five cycles. A setting of 1 gives a single one-cycle strobe, and a setting of 5 gives a five-pulse train.

The generator cannot be retriggered. While the burst is running, the trigger is not examined at all. After the last pulse, the block waits for the trigger to go low before it arms again, so a trigger held high yields exactly one burst. The trigger must already be synchronous to the clock and must change much more slowly than the clock.

The state register is one-hot, with one flip-flop for each state. The states are armed, one state for each high or low cycle of the burst, and a wait-for-low state. Any register pattern that does not have exactly one bit set is replaced by the armed code on the next edge.

Top module: `edge_pulse_gen`

## Requirements
- R1: After reset, `pulse_o` is 0, and it stays 0 for as long as `trig_i` stays low.
- R2: If `trig_i` is sampled 1 at a clock edge while the block is armed, `pulse_o` is 1 for the clock period that follows that edge.
- R3: A burst has exactly `NUM_PULSES` high cycles. Counting the first pulse cycle as cycle 0, the high cycles are the even cycles 0, 2, …, 2·(`NUM_PULSES`−1). All other cycles of the burst are low.
- R4: During a burst, `trig_i` is ignored. If it falls and rises again inside the burst, the burst is neither shortened nor extended, and no second burst starts.
- R5: While `trig_i` stays high after a burst, `pulse_o` stays 0.
- R6: One clock edge with `trig_i` sampled 0 after a burst is enough to re-arm the block. The next sampled 1 then starts a new burst with the timing of R2.
- R7: Exactly one state flip-flop is set at all times. As a consequence, `pulse_o` is never high in two consecutive cycles.
- R8: The synchronous reset `rst` aborts any burst. `pulse_o` is 0 in the cycle after the edge at which `rst` is sampled high, and the block is armed once reset is released.
- R9: The burst length follows `NUM_PULSES`. With 1 the block gives a single one-cycle pulse; with 5 it gives five pulses over nine cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Trigger level, already synchronous to `clk` |
| pulse_o | output | 1 | Pulse output, decoded directly from the state flip-flops |

## Verification
Every state flip-flop is visible at the output within a few cycles, so a wrong internal state shows up quickly. A wrongly set burst bit gives an extra or misplaced pulse in the very next period. A lost wait-for-low bit gives a second burst one cycle after the first one ends, while the trigger is still high. A stuck armed bit makes the block either never fire or fire again within two cycles. The bench therefore compares the output cycle by cycle against the expected high/low pattern for three burst lengths. It also watches continuously for two adjacent high cycles.

// File: rtl/eps_pkg.sv
package eps_pkg;

    // Number of flops in the burst chain: N high cycles with N-1 gaps between them.
    function automatic int unsigned burst_chain_len(input int unsigned n_pulses);
        return 2 * n_pulses - 1;
    endfunction

    // Total one-hot width: armed + burst chain + wait-for-low.
    function automatic int unsigned state_bits(input int unsigned n_pulses);
        return burst_chain_len(n_pulses) + 2;
    endfunction

    // Bit position of the armed state; the reset code sets only this bit.
    localparam int unsigned ARMED_POS = 0;

endpackage

// File: rtl/eps_next_state.sv
module eps_next_state #(
    parameter int unsigned NUM_PULSES = 3,
    localparam int unsigned CW = eps_pkg::burst_chain_len(NUM_PULSES),
    localparam int unsigned SW = eps_pkg::state_bits(NUM_PULSES)
) (
    input  logic [SW-1:0] state_q,
    input  logic          trig_i,
    output logic [SW-1:0] state_d
);

    // Layout from MSB down: wait-for-low, burst chain, armed.
    typedef struct packed {
        logic          hold;
        logic [CW-1:0] chain;
        logic          armed;
    } fsm_t;

    localparam fsm_t RECOVER = fsm_t'(SW'(1) << eps_pkg::ARMED_POS);

    fsm_t          cur_q;
    fsm_t          nxt_d;
    logic [CW-1:0] chain_d;
    logic          legal_q;

    assign cur_q = fsm_t'(state_q);

    // The burst chain is a pure shift: only its entry looks at the trigger.
    assign chain_d[0] = cur_q.armed & trig_i;
    for (genvar j = 1; j < CW; j++) begin : g_chain
        assign chain_d[j] = cur_q.chain[j-1];
    end

    assign legal_q = $onehot(state_q);

    always_comb begin
        nxt_d.armed = (cur_q.armed & ~trig_i) | (cur_q.hold & ~trig_i);
        nxt_d.chain = chain_d;
        nxt_d.hold  = (cur_q.hold & trig_i) | cur_q.chain[CW-1];
        if (!legal_q) begin
            nxt_d = RECOVER;
        end
    end

    assign state_d = nxt_d;

endmodule

// File: rtl/eps_state_reg.sv
module eps_state_reg #(
    parameter int unsigned     SW      = 3,
    parameter logic [SW-1:0]   RST_VAL = SW'(1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] state_d,
    output logic [SW-1:0] state_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_VAL;
        end else begin
            state_q <= state_d;
        end
    end

    // R7: one flop per state, exactly one of them set.
    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1)
        else $error("state register not one-hot");

endmodule

// File: rtl/eps_pulse_decode.sv
module eps_pulse_decode #(
    parameter int unsigned NUM_PULSES = 3,
    localparam int unsigned CW = eps_pkg::burst_chain_len(NUM_PULSES)
) (
    input  logic [CW-1:0] chain_q,
    output logic          pulse_o
);

    // Even chain positions are the high cycles; odd positions are the gaps.
    logic [CW-1:0] high_mask;

    for (genvar j = 0; j < CW; j++) begin : g_mask
        assign high_mask[j] = ((j % 2) == 0);
    end

    assign pulse_o = |(chain_q & high_mask);

endmodule

// File: rtl/edge_pulse_gen.sv
module edge_pulse_gen #(
    parameter int unsigned NUM_PULSES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int unsigned CW = eps_pkg::burst_chain_len(NUM_PULSES);
    localparam int unsigned SW = eps_pkg::state_bits(NUM_PULSES);
    localparam logic [SW-1:0] ARMED_CODE = SW'(1) << eps_pkg::ARMED_POS;

    logic [SW-1:0] state_d;
    logic [SW-1:0] state_q;
    logic [CW-1:0] chain_q;
    logic          armed_q;
    logic          hold_q;

    assign armed_q = state_q[eps_pkg::ARMED_POS];
    assign chain_q = state_q[CW:1];
    assign hold_q  = state_q[SW-1];

    eps_next_state #(
        .NUM_PULSES (NUM_PULSES)
    ) u_next (
        .state_q (state_q),
        .trig_i  (trig_i),
        .state_d (state_d)
    );

    eps_state_reg #(
        .SW      (SW),
        .RST_VAL (ARMED_CODE)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .state_d (state_d),
        .state_q (state_q)
    );

    eps_pulse_decode #(
        .NUM_PULSES (NUM_PULSES)
    ) u_dec (
        .chain_q (chain_q),
        .pulse_o (pulse_o)
    );

    // R2: an armed block that samples the trigger high pulses in the next period.
    p_fire_r2: assert property (@(posedge clk) disable iff (rst)
        (armed_q && trig_i) |=> pulse_o)
        else $error("no pulse after armed trigger");

    // R3: every pulse is followed by a low cycle.
    p_gap_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o)
        else $error("pulse longer than one cycle");

    // R4: while the burst runs, the block cannot fall back to armed.
    p_no_abort_r4: assert property (@(posedge clk) disable iff (rst)
        (chain_q != '0) |=> !armed_q)
        else $error("burst left early");

    // R5: a held trigger keeps the block waiting and silent.
    p_no_refire_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_q && trig_i) |=> (hold_q && !pulse_o))
        else $error("refire while trigger held");

    // R6: one low sample in the wait state re-arms.
    p_rearm_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !trig_i) |=> armed_q)
        else $error("no re-arm after trigger low");

    // R8: reset silences the output and arms the block.
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (armed_q && !pulse_o))
        else $error("reset did not arm");

endmodule

// File: tb/edge_pulse_gen_test.sv
`timescale 1ns/1ps
module edge_pulse_gen_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic pulse3;
    logic pulse1;
    logic pulse5;

    int checks = 0;
    int errors = 0;
    int doubles = 0;
    bit done = 1'b0;
    logic prev3 = 1'b0;
    logic prev1 = 1'b0;
    logic prev5 = 1'b0;

    always #2.5 clk = ~clk;

    edge_pulse_gen #(.NUM_PULSES(3)) uut (
        .clk(clk), .rst(rst), .trig_i(trig), .pulse_o(pulse3));

    edge_pulse_gen #(.NUM_PULSES(1)) uut_single (
        .clk(clk), .rst(rst), .trig_i(trig), .pulse_o(pulse1));

    edge_pulse_gen #(.NUM_PULSES(5)) uut_five (
        .clk(clk), .rst(rst), .trig_i(trig), .pulse_o(pulse5));

    // R7 monitor: no output may stay high for two adjacent cycles.
    always @(negedge clk) begin
        if (!rst) begin
            if ((pulse3 && prev3) || (pulse1 && prev1) || (pulse5 && prev5)) doubles++;
        end
        prev3 = pulse3;
        prev1 = pulse1;
        prev5 = pulse5;
    end

    function automatic logic exp_pulse(input int c, input int n);
        return ((c < 2 * n - 1) && ((c % 2) == 0)) ? 1'b1 : 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, expv);
        end
    endtask

    task automatic all_low(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk(req, "N3 low", pulse3, 1'b0);
            chk(req, "N1 low", pulse1, 1'b0);
            chk(req, "N5 low", pulse5, 1'b0);
        end
    endtask

    // Caller raises trig at a negedge; cycle 0 is the next negedge sample.
    task automatic burst_check(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk((c == 0) ? "R2" : req, $sformatf("N3 c%0d", c), pulse3, exp_pulse(c, 3));
            chk("R9", $sformatf("N1 c%0d", c), pulse1, exp_pulse(c, 1));
            chk("R9", $sformatf("N5 c%0d", c), pulse5, exp_pulse(c, 5));
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R1", "N3 in reset", pulse3, 1'b0);
        chk("R1", "N5 in reset", pulse5, 1'b0);
        rst = 1'b0;
        all_low("R1", 6);
    endtask

    task automatic t_first_burst();
        trig = 1'b1;
        burst_check("R3", 12);
        all_low("R5", 10);
    endtask

    task automatic t_rearm();
        trig = 1'b0;
        @(negedge clk);
        trig = 1'b1;
        burst_check("R6", 12);
        trig = 1'b0;
        all_low("R6", 6);
    endtask

    // R4: trigger drops after the first pulse and returns mid-burst.
    task automatic t_ignore_during_burst();
        trig = 1'b1;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            chk("R4", $sformatf("N3 c%0d", c), pulse3, exp_pulse(c, 3));
            chk("R4", $sformatf("N5 c%0d", c), pulse5, exp_pulse(c, 5));
            if (c == 0) trig = 1'b0;
            if (c == 2) trig = 1'b1;
        end
        all_low("R5", 4);
        trig = 1'b0;
        all_low("R6", 4);
    endtask

    task automatic t_reset_abort();
        trig = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3", "N3 mid-burst high", pulse3, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk("R8", "N3 after reset", pulse3, 1'b0);
        chk("R8", "N5 after reset", pulse5, 1'b0);
        trig = 1'b0;
        all_low("R8", 2);
        rst = 1'b0;
        all_low("R8", 3);
        trig = 1'b1;
        burst_check("R8", 12);
        trig = 1'b0;
        all_low("R8", 4);
    endtask

    task automatic t_no_adjacent();
        checks++;
        if (doubles != 0) begin
            errors++;
            $display("FAIL R7 adjacent high cycles: actual %0d expected 0", doubles);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_first_burst();
        t_rearm();
        t_ignore_during_burst();
        t_reset_abort();
        t_no_adjacent();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule